// File: doc/BRIEF.md
# Registered Tri-Port Bus Exchanger

This block sits between a processor data bus (port A) and two memory banks (ports 1B and 2B). It lets a processor bus be interleaved across the two banks. Words written from port A are captured into two per-bank forward registers, which drive the bank ports. Words coming back from either bank are captured into two return registers. One of the two return registers is then steered onto port A.

Every register shares one clock. Each data register has its own active-low load strobe. The two output enables and the bank select are also captured on the clock edge. As a result, a change of direction or a change of bank takes effect only at an edge.

Each pin group is modelled as three signals: an input word, an output word and a drive flag. The drive flag is high when the port actively drives its pins, and no internal tri-state is used. A synchronous reset returns the block to a quiet state.

Top module: `tri_port_xchg`

## Requirements
- R1: When `ld_a1_n` is low at a rising edge, `b1_out` shows the `a_in` value sampled at that edge from the next cycle on.
- R2: When `ld_a2_n` is low at a rising edge, `b2_out` shows the sampled `a_in`. Both bank registers may load the same word at the same edge.
- R3: A data register whose load strobe is high at an edge keeps its previous contents, whatever its data input does.
- R4: `ld_1a_n` low at an edge captures `b1_in` into the bank-1 return register. `ld_2a_n` low at an edge captures `b2_in` into the bank-2 return register.
- R5: `bank1_sel` is sampled at the edge. After an edge with it high (1), `a_out` shows the bank-1 return register. After an edge with it low (0), `a_out` shows the bank-2 return register.
- R6: `a_drv` becomes 1 only after an edge at which `a_en_n` was sampled 0. It becomes 0 after an edge at which `a_en_n` was sampled 1. A change of `a_en_n` between edges leaves `a_drv` unchanged.
- R7: One registered bank enable `b_en_n` sets `b1_drv` and `b2_drv` together, with the same one-edge delay as R6. While both flags are 0, the return registers still load from `b1_in`/`b2_in`.
- R8: A synchronous reset (`rst` high at an edge) clears all four data registers to 0, sets `a_drv`, `b1_drv` and `b2_drv` to 0, and sets the select to bank 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | DW | Word arriving on port A |
| a_out | output | DW | Selected return word for port A |
| a_drv | output | 1 | Port A drive flag |
| b1_in | input | DW | Word arriving on bank port 1 |
| b1_out | output | DW | Bank 1 forward register |
| b1_drv | output | 1 | Bank port 1 drive flag |
| b2_in | input | DW | Word arriving on bank port 2 |
| b2_out | output | DW | Bank 2 forward register |
| b2_drv | output | 1 | Bank port 2 drive flag |
| ld_a1_n | input | 1 | Load strobe, A to bank 1, active low |
| ld_a2_n | input | 1 | Load strobe, A to bank 2, active low |
| ld_1a_n | input | 1 | Load strobe, bank 1 return, active low |
| ld_2a_n | input | 1 | Load strobe, bank 2 return, active low |
| bank1_sel | input | 1 | Return bank select, 1 = bank 1 |
| a_en_n | input | 1 | Port A drive request, active low |
| b_en_n | input | 1 | Bank ports drive request, active low |

## Verification
The tests write one word to both banks at the same edge. This tells two independent load paths apart from a single shared one.

Other tests alternate the select on every cycle after loading distinct return words. This shows whether the select is sampled at the edge or passed straight through.

Hold tests change the data inputs while the strobes stay high, which separates a true enable from a free-running register. Drive requests are changed mid-cycle and checked before and after the next edge, which exposes any combinational enable path.

A long random run with a fixed seed then mixes all strobes, selects and enables against a bench model.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
   typedef enum logic [1:0] {
      P_A1 = 2'd0,
      P_A2 = 2'd1,
      P_1A = 2'd2,
      P_2A = 2'd3
   } path_e;
   localparam int NPATH = 4;
endpackage

// File: rtl/xchg_cereg.sv
module xchg_cereg #(
   parameter int DW = 12,
   parameter bit RST_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en_n,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);
   if (DW < 1) begin : g_bad_dw
      $error("xchg_cereg: DW must be at least 1");
   end

   if (RST_EN) begin : g_rst
      always_ff @(posedge clk) begin
         if (rst)        q <= '0;
         else if (!en_n) q <= d;
      end
   end else begin : g_norst
      always_ff @(posedge clk) begin
         if (!en_n) q <= d;
      end
   end

   // R3
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(en_n)) |-> $stable(q));

   // R1
   load_when_strobed_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(en_n)) |-> (q == $past(d)));
endmodule

// File: rtl/xchg_ctl.sv
module xchg_ctl (
   input  logic clk,
   input  logic rst,
   input  logic a_en_n,
   input  logic b_en_n,
   input  logic bank1_sel,
   output logic a_drv,
   output logic b_drv,
   output logic sel_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         a_drv <= 1'b0;
         b_drv <= 1'b0;
         sel_q <= 1'b0;
      end else begin
         a_drv <= ~a_en_n;
         b_drv <= ~b_en_n;
         sel_q <= bank1_sel;
      end
   end

   // R6
   a_drv_delay_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (a_drv == !$past(a_en_n)));

   // R7
   b_drv_delay_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (b_drv == !$past(b_en_n)));
endmodule

// File: rtl/tri_port_xchg.sv
module tri_port_xchg
   import xchg_pkg::*;
#(
   parameter int DW = 12,
   parameter bit DATA_RST = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [DW-1:0] a_in,
   output logic [DW-1:0] a_out,
   output logic          a_drv,
   input  logic [DW-1:0] b1_in,
   output logic [DW-1:0] b1_out,
   output logic          b1_drv,
   input  logic [DW-1:0] b2_in,
   output logic [DW-1:0] b2_out,
   output logic          b2_drv,
   input  logic          ld_a1_n,
   input  logic          ld_a2_n,
   input  logic          ld_1a_n,
   input  logic          ld_2a_n,
   input  logic          bank1_sel,
   input  logic          a_en_n,
   input  logic          b_en_n
);
   if (DW < 1 || DW > 1024) begin : g_bad_dw
      $error("tri_port_xchg: DW out of range");
   end

   logic [DW-1:0]    d_bus [NPATH];
   logic [DW-1:0]    q_bus [NPATH];
   logic [NPATH-1:0] ld_n;
   logic             b_drv_q;
   logic             sel_q;

   assign d_bus[int'(P_A1)] = a_in;
   assign d_bus[int'(P_A2)] = a_in;
   assign d_bus[int'(P_1A)] = b1_in;
   assign d_bus[int'(P_2A)] = b2_in;
   assign ld_n = {ld_2a_n, ld_1a_n, ld_a2_n, ld_a1_n};

   for (genvar g = 0; g < NPATH; g++) begin : g_path
      xchg_cereg #(.DW(DW), .RST_EN(DATA_RST)) u_reg (
         .clk  (clk),
         .rst  (rst),
         .en_n (ld_n[g]),
         .d    (d_bus[g]),
         .q    (q_bus[g])
      );
   end

   xchg_ctl u_ctl (
      .clk       (clk),
      .rst       (rst),
      .a_en_n    (a_en_n),
      .b_en_n    (b_en_n),
      .bank1_sel (bank1_sel),
      .a_drv     (a_drv),
      .b_drv     (b_drv_q),
      .sel_q     (sel_q)
   );

   assign b1_out = q_bus[int'(P_A1)];
   assign b2_out = q_bus[int'(P_A2)];
   assign b1_drv = b_drv_q;
   assign b2_drv = b_drv_q;
   assign a_out  = sel_q ? q_bus[int'(P_1A)] : q_bus[int'(P_2A)];

   // R5
   sel_bank1_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(bank1_sel) && !$past(ld_1a_n)) |-> (a_out == $past(b1_in)));

   // R4
   sel_bank2_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(bank1_sel) && !$past(ld_2a_n)) |-> (a_out == $past(b2_in)));

   // R7
   b_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(b_en_n)) |-> (!b1_drv && !b2_drv));

   // R8
   reset_quiet_chk: assert property (@(posedge clk)
      $past(rst) |-> (!a_drv && !b1_drv && !b2_drv));
endmodule

// File: tb/sim_tri_port_xchg.sv
`timescale 1ns/1ps
module sim_tri_port_xchg;
   localparam int DW = 12;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [DW-1:0] a_in = '0, b1_in = '0, b2_in = '0;
   logic [DW-1:0] a_out, b1_out, b2_out;
   logic a_drv, b1_drv, b2_drv;
   logic ld_a1_n = 1'b1, ld_a2_n = 1'b1, ld_1a_n = 1'b1, ld_2a_n = 1'b1;
   logic bank1_sel = 1'b0, a_en_n = 1'b1, b_en_n = 1'b1;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [DW-1:0] m_a1, m_a2, m_1a, m_2a;
   logic m_sel, m_adrv, m_bdrv;

   always #4 clk = ~clk;

   tri_port_xchg #(.DW(DW)) u0 (
      .clk(clk), .rst(rst),
      .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
      .b1_in(b1_in), .b1_out(b1_out), .b1_drv(b1_drv),
      .b2_in(b2_in), .b2_out(b2_out), .b2_drv(b2_drv),
      .ld_a1_n(ld_a1_n), .ld_a2_n(ld_a2_n), .ld_1a_n(ld_1a_n), .ld_2a_n(ld_2a_n),
      .bank1_sel(bank1_sel), .a_en_n(a_en_n), .b_en_n(b_en_n)
   );

   function automatic logic [DW-1:0] exp_a_out();
      return m_sel ? m_1a : m_2a;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // advance one edge, update the model, then move to the falling edge
   task automatic step();
      @(posedge clk);
      if (rst) begin
         m_a1 = '0; m_a2 = '0; m_1a = '0; m_2a = '0;
         m_sel = 1'b0; m_adrv = 1'b0; m_bdrv = 1'b0;
      end else begin
         if (!ld_a1_n) m_a1 = a_in;
         if (!ld_a2_n) m_a2 = a_in;
         if (!ld_1a_n) m_1a = b1_in;
         if (!ld_2a_n) m_2a = b2_in;
         m_sel = bank1_sel;
         m_adrv = ~a_en_n;
         m_bdrv = ~b_en_n;
      end
      @(negedge clk);
   endtask

   task automatic check_all();
      chk("R1 b1_out", int'(b1_out), int'(m_a1));
      chk("R2 b2_out", int'(b2_out), int'(m_a2));
      chk("R5 a_out", int'(a_out), int'(exp_a_out()));
      chk("R6 a_drv", int'(a_drv), int'(m_adrv));
      chk("R7 b1_drv", int'(b1_drv), int'(m_bdrv));
      chk("R7 b2_drv", int'(b2_drv), int'(m_bdrv));
   endtask

   task automatic idle();
      ld_a1_n = 1'b1; ld_a2_n = 1'b1; ld_1a_n = 1'b1; ld_2a_n = 1'b1;
   endtask

   initial begin
      void'($urandom(32'd2024));
      @(negedge clk);
      a_in = 12'hFFF; b1_in = 12'hFFF; b2_in = 12'hFFF;
      ld_a1_n = 1'b0; ld_a2_n = 1'b0; ld_1a_n = 1'b0; ld_2a_n = 1'b0;
      bank1_sel = 1'b1; a_en_n = 1'b0; b_en_n = 1'b0;
      step(); step();
      // R8: reset wins over loads and enables
      chk("R8 b1_out", int'(b1_out), 0);
      chk("R8 b2_out", int'(b2_out), 0);
      chk("R8 a_out", int'(a_out), 0);
      chk("R8 a_drv", int'(a_drv), 0);
      chk("R8 b_drv", int'(b1_drv | b2_drv), 0);
      rst = 1'b0; idle(); bank1_sel = 1'b0; a_en_n = 1'b1; b_en_n = 1'b1;
      step(); check_all();

      // R2: one A word into both banks at the same edge
      a_in = 12'hABC; ld_a1_n = 1'b0; ld_a2_n = 1'b0;
      step(); idle();
      chk("R2 both b1", int'(b1_out), 12'hABC);
      chk("R2 both b2", int'(b2_out), 12'hABC);

      // R3: strobes high, inputs change, contents held
      a_in = 12'h123; b1_in = 12'h456; b2_in = 12'h789;
      step();
      chk("R3 hold b1", int'(b1_out), 12'hABC);
      chk("R3 hold b2", int'(b2_out), 12'hABC);
      chk("R3 hold ret", int'(a_out), 0);

      // R4/R7: return registers load while bank drive flags are 0
      b1_in = 12'h111; b2_in = 12'h222; ld_1a_n = 1'b0; ld_2a_n = 1'b0;
      step(); idle();
      chk("R7 quiet b", int'(b1_drv), 0);
      chk("R4 ret2", int'(a_out), 12'h222);

      // R5: alternate the select on every cycle
      for (int i = 0; i < 6; i++) begin
         bank1_sel = (i % 2 == 0);
         chk("R5 pre-edge", int'(a_out), (i % 2 == 0) ? 12'h222 : 12'h111);
         step();
         chk("R5 interleave", int'(a_out), (i % 2 == 0) ? 12'h111 : 12'h222);
      end

      // R6/R7: enable requests show up only after the next edge
      a_en_n = 1'b0; b_en_n = 1'b0;
      #1;
      chk("R6 no early a_drv", int'(a_drv), 0);
      chk("R7 no early b_drv", int'(b1_drv), 0);
      step();
      chk("R6 a_drv on", int'(a_drv), 1);
      chk("R7 b1 on", int'(b1_drv), 1);
      chk("R7 b2 on", int'(b2_drv), 1);
      a_en_n = 1'b1; b_en_n = 1'b1;
      #1;
      chk("R6 no early off", int'(a_drv), 1);
      step();
      chk("R6 a_drv off", int'(a_drv), 0);
      chk("R7 b off", int'(b2_drv), 0);

      // random mix
      for (int n = 0; n < 400; n++) begin
         a_in = DW'($urandom); b1_in = DW'($urandom); b2_in = DW'($urandom);
         ld_a1_n = 1'($urandom); ld_a2_n = 1'($urandom);
         ld_1a_n = 1'($urandom); ld_2a_n = 1'($urandom);
         bank1_sel = 1'($urandom); a_en_n = 1'($urandom); b_en_n = 1'($urandom);
         step();
         check_all();
      end

      // R8: reset mid-run
      rst = 1'b1; step(); rst = 1'b0; idle();
      chk("R8 rerun a_drv", int'(a_drv), 0);
      chk("R8 rerun b1", int'(b1_out), 0);
      chk("R8 rerun a_out", int'(a_out), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule